// File: doc/BRIEF.md
# Context Validation Tag Generator

This unit derives an 8-bit validation tag for a connection context. A 24-bit connection identifier, a 4-bit region and a 4-bit type are packed into one 32-bit word. A CRC-8 with generator x^8+x^2+x+1 runs over that word in a single step, starting from an all-ones register. The result is folded into a tag byte whose top bit marks the context as valid. Two tag layouts exist. The full layout keeps seven CRC bits. The typed layout carries the context type next to three CRC bits.

The same unit also produces the invalidated form of a tag byte that is already stored. This is the byte with its valid bit cleared, which lets a context be retired without recomputing anything.

A request is presented with a one-cycle input strobe. With the default registered output, results appear on the next clock edge together with an output strobe. Between requests, the results hold their last values.

Top module: `ctx_tag_unit`

## Requirements
- R1: The CRC input word is `{cid[23:0], region[3:0], type[3:0]}`, with the identifier in bits 31..8, the region in bits 7..4 and the type in bits 3..0.
- R2: `out_crc` is the non-reflected CRC-8 with generator 0x07 (x^8+x^2+x+1) over the 32-bit word, word bit 31 entering first. For example, CRC bit 0 equals the XOR of word bits 0,6,7,8,12,14,16,18,19,21,23,28,30,31 and seed bits 4,6,7.
- R3: The CRC register starts from 0xFF for every request, so an all-zero word gives the CRC of 32 zero bits from seed 0xFF, and no earlier request affects the result.
- R4: With `in_mode` = 0 (full layout), `out_tag` = 0x80 OR `out_crc[6:0]`.
- R5: With `in_mode` = 1 (typed layout), `out_tag[7]` = 1, `out_tag[6:3]` = type and `out_tag[2:0]` = `out_crc[2:0]`.
- R6: `out_inval` equals `in_stored` with bit 7 cleared and bits 6..0 unchanged, whatever the mode.
- R7: `out_valid` is high in exactly the cycle after each accepted `in_valid`. While `in_valid` is low, the result outputs keep their last values even when the inputs change.
- R8: During and right after reset, `out_valid`, `out_crc`, `out_tag` and `out_inval` are all zero.
- R9: Every result delivered with `out_valid` has `out_tag[7]` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe, one cycle per request |
| in_cid | input | 24 | Connection identifier |
| in_region | input | 4 | Context region |
| in_type | input | 4 | Context type |
| in_mode | input | 1 | Tag layout: 0 full, 1 typed |
| in_stored | input | 8 | Stored tag byte to invalidate |
| out_valid | output | 1 | Result strobe |
| out_crc | output | 8 | Raw CRC-8 of the packed word |
| out_tag | output | 8 | Tag byte with valid bit |
| out_inval | output | 8 | Stored byte with valid bit cleared |

## Verification
The only state in this unit is the set of output registers, plus the CRC chain, which is combinational but deep. A broken chain stage, a misplaced field or a wrong seed therefore shows up in `out_crc` one cycle after the strobe, and only for words that exercise the broken bit. For that reason, single-bit words and words with dense random bits are mixed. A register that fails to hold, or a strobe that is lost or duplicated, shows up on the cycle right after an idle input, when the inputs have been changed on purpose.

// File: rtl/ctx_tag_pkg.sv
package ctx_tag_pkg;

   // Tag layout selector
   typedef enum logic {
      TAG_FULL  = 1'b0,
      TAG_TYPED = 1'b1
   } tag_mode_e;

   localparam int unsigned DEF_ID_W  = 24;
   localparam int unsigned DEF_FLD_W = 4;
   localparam int unsigned DEF_CRC_W = 8;
   localparam logic [7:0]  DEF_POLY  = 8'h07;
   localparam logic [7:0]  DEF_SEED  = 8'hFF;

endpackage

// File: rtl/ctx_word_pack.sv
module ctx_word_pack #(
   parameter int unsigned ID_W  = 24,
   parameter int unsigned FLD_W = 4,
   localparam int unsigned WORD_W = ID_W + 2 * FLD_W
) (
   input  logic [ID_W-1:0]   cid,
   input  logic [FLD_W-1:0]  region,
   input  logic [FLD_W-1:0]  ctype,
   output logic [WORD_W-1:0] word
);
   // identifier on top, region in the middle, type at the bottom
   assign word = {cid, region, ctype};
endmodule

// File: rtl/ctx_crc_engine.sv
module ctx_crc_engine #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CRC_W  = 8,
   parameter logic [CRC_W-1:0] POLY = 8'h07,
   parameter logic [CRC_W-1:0] SEED = 8'hFF
) (
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc
);
   // one serial shift step of a non-reflected CRC
   function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                 input logic d);
      logic fb;
      fb = c[CRC_W-1] ^ d;
      crc_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : {CRC_W{1'b0}});
   endfunction

   logic [CRC_W-1:0] chain [DATA_W+1];

   assign chain[0] = SEED;

   // unrolled chain: most significant data bit enters first
   for (genvar s = 0; s < DATA_W; s++) begin : g_stage
      assign chain[s+1] = crc_step(chain[s], data[DATA_W-1-s]);
   end

   assign crc = chain[DATA_W];
endmodule

// File: rtl/ctx_tag_form.sv
module ctx_tag_form
   import ctx_tag_pkg::*;
#(
   parameter int unsigned CRC_W = 8,
   parameter int unsigned FLD_W = 4,
   localparam int unsigned LOW_KEEP = CRC_W - 1 - FLD_W
) (
   input  logic [CRC_W-1:0] crc,
   input  logic [FLD_W-1:0] ctype,
   input  tag_mode_e        mode,
   input  logic [CRC_W-1:0] stored,
   output logic [CRC_W-1:0] tag,
   output logic [CRC_W-1:0] inval
);
   logic [CRC_W-1:0] tag_full;
   logic [CRC_W-1:0] tag_typed;

   assign tag_full  = {1'b1, crc[CRC_W-2:0]};
   assign tag_typed = {1'b1, ctype, crc[LOW_KEEP-1:0]};

   always_comb begin
      unique case (mode)
         TAG_TYPED: tag = tag_typed;
         default:   tag = tag_full;
      endcase
   end

   assign inval = {1'b0, stored[CRC_W-2:0]};
endmodule

// File: rtl/ctx_tag_unit.sv
module ctx_tag_unit
   import ctx_tag_pkg::*;
#(
   parameter int unsigned ID_W    = DEF_ID_W,
   parameter int unsigned FLD_W   = DEF_FLD_W,
   parameter int unsigned CRC_W   = DEF_CRC_W,
   parameter logic [CRC_W-1:0] POLY = DEF_POLY,
   parameter logic [CRC_W-1:0] SEED = DEF_SEED,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned WORD_W = ID_W + 2 * FLD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [ID_W-1:0]  in_cid,
   input  logic [FLD_W-1:0] in_region,
   input  logic [FLD_W-1:0] in_type,
   input  logic             in_mode,
   input  logic [CRC_W-1:0] in_stored,
   output logic             out_valid,
   output logic [CRC_W-1:0] out_crc,
   output logic [CRC_W-1:0] out_tag,
   output logic [CRC_W-1:0] out_inval
);
   // elaboration-time parameter checks
   if (CRC_W < FLD_W + 2) begin : g_bad_crc_w
      $error("CRC_W must leave room for valid bit, type field and one CRC bit");
   end
   if (ID_W == 0 || FLD_W == 0) begin : g_bad_fields
      $error("ID_W and FLD_W must be non-zero");
   end

   logic [WORD_W-1:0] word;
   logic [CRC_W-1:0]  crc_c;
   logic [CRC_W-1:0]  tag_c;
   logic [CRC_W-1:0]  inval_c;

   ctx_word_pack #(.ID_W(ID_W), .FLD_W(FLD_W)) u_pack (
      .cid    (in_cid),
      .region (in_region),
      .ctype  (in_type),
      .word   (word)
   );

   ctx_crc_engine #(.DATA_W(WORD_W), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_crc (
      .data (word),
      .crc  (crc_c)
   );

   ctx_tag_form #(.CRC_W(CRC_W), .FLD_W(FLD_W)) u_form (
      .crc    (crc_c),
      .ctype  (in_type),
      .mode   (tag_mode_e'(in_mode)),
      .stored (in_stored),
      .tag    (tag_c),
      .inval  (inval_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_crc   <= '0;
            out_tag   <= '0;
            out_inval <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_crc   <= crc_c;
               out_tag   <= tag_c;
               out_inval <= inval_c;
            end
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_crc   = crc_c;
      assign out_tag   = tag_c;
      assign out_inval = inval_c;
   end
endmodule

// File: rtl/ctx_tag_unit_chk.sv
module ctx_tag_unit_chk #(
   parameter int unsigned ID_W    = 24,
   parameter int unsigned FLD_W   = 4,
   parameter int unsigned CRC_W   = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [FLD_W-1:0] in_type,
   input logic             in_mode,
   input logic [CRC_W-1:0] in_stored,
   input logic             out_valid,
   input logic [CRC_W-1:0] out_crc,
   input logic [CRC_W-1:0] out_tag,
   input logic [CRC_W-1:0] out_inval
);
   localparam int unsigned LOW_KEEP = CRC_W - 1 - FLD_W;

   // R9
   tag_valid_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_tag[CRC_W-1]);

   if (OUT_REG) begin : g_seq
      // R7
      strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);

      // R7
      no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);

      // R7
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(out_crc) && $stable(out_tag) && $stable(out_inval)));

      // R4
      full_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !in_mode) |=> (out_tag[CRC_W-2:0] == out_crc[CRC_W-2:0]));

      // R5
      typed_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_mode) |=>
            ((out_tag[CRC_W-2 -: FLD_W] == $past(in_type)) &&
             (out_tag[LOW_KEEP-1:0] == out_crc[LOW_KEEP-1:0])));

      // R6
      inval_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (!out_inval[CRC_W-1] &&
                       out_inval[CRC_W-2:0] == $past(in_stored[CRC_W-2:0])));
   end
endmodule

bind ctx_tag_unit ctx_tag_unit_chk #(
   .ID_W(ID_W), .FLD_W(FLD_W), .CRC_W(CRC_W), .OUT_REG(OUT_REG)
) u_ctx_tag_unit_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_type   (in_type),
   .in_mode   (in_mode),
   .in_stored (in_stored),
   .out_valid (out_valid),
   .out_crc   (out_crc),
   .out_tag   (out_tag),
   .out_inval (out_inval)
);

// File: tb/test_ctx_tag_unit.sv
`timescale 1ns/1ps
module test_ctx_tag_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [23:0] in_cid = '0;
   logic [3:0]  in_region = '0;
   logic [3:0]  in_type = '0;
   logic        in_mode = 1'b0;
   logic [7:0]  in_stored = '0;
   logic        out_valid;
   logic [7:0]  out_crc;
   logic [7:0]  out_tag;
   logic [7:0]  out_inval;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ctx_tag_unit i_ctx_tag_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cid(in_cid),
      .in_region(in_region), .in_type(in_type), .in_mode(in_mode),
      .in_stored(in_stored), .out_valid(out_valid), .out_crc(out_crc),
      .out_tag(out_tag), .out_inval(out_inval)
   );

   // bit-serial reference, word bit 31 first, seed 0xFF, generator 0x07
   function automatic logic [7:0] ref_crc(input logic [31:0] w);
      logic [7:0] c = 8'hFF;
      for (int i = 31; i >= 0; i--) begin
         logic fb = c[7] ^ w[i];
         c = {c[6:0], 1'b0};
         if (fb) c = c ^ 8'h07;
      end
      return c;
   endfunction

   // closed-form equation of CRC bit 0 with seed bits 4,6,7 all one
   function automatic logic ref_bit0(input logic [31:0] w);
      return (^(w & 32'hD0AD51C1)) ^ 1'b1;
   endfunction

   function automatic logic [7:0] ref_tag(input logic [7:0] c, input logic [3:0] t,
                                          input logic m);
      return m ? {1'b1, t, c[2:0]} : {1'b1, c[6:0]};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one request at the falling edge, check after the next rising edge
   task automatic req(input logic [23:0] cid, input logic [3:0] rg, input logic [3:0] ty,
                      input logic md, input logic [7:0] st, input string tagname);
      logic [31:0] w;
      logic [7:0]  c;
      @(negedge clk);
      in_valid = 1'b1; in_cid = cid; in_region = rg; in_type = ty;
      in_mode = md; in_stored = st;
      w = {cid, rg, ty};
      c = ref_crc(w);
      @(posedge clk); #1;
      chk({"R7 valid ", tagname}, {7'd0, out_valid}, 8'd1);
      chk({"R1/R2 crc ", tagname}, out_crc, c);
      chk({"R2 bit0 equation ", tagname}, {7'd0, out_crc[0]}, {7'd0, ref_bit0(w)});
      chk(md ? {"R5 typed tag ", tagname} : {"R4 full tag ", tagname},
          out_tag, ref_tag(c, ty, md));
      chk({"R9 tag msb ", tagname}, {7'd0, out_tag[7]}, 8'd1);
      chk({"R6 inval ", tagname}, out_inval, st & 8'h7F);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] held_crc, held_tag, held_inval;
      int unsigned seed_v;
      seed_v = $urandom(32'h5EED_C0DE);
      repeat (3) @(posedge clk);
      #1;
      // R8 reset state
      chk("R8 valid in reset", {7'd0, out_valid}, 8'd0);
      chk("R8 crc in reset", out_crc, 8'd0);
      chk("R8 tag in reset", out_tag, 8'd0);
      chk("R8 inval in reset", out_inval, 8'd0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R8 valid after reset", {7'd0, out_valid}, 8'd0);
      chk("R8 crc after reset", out_crc, 8'd0);

      // R3 all-zero word, seeded from all ones
      req(24'h0, 4'h0, 4'h0, 1'b0, 8'h00, "zero word");
      req(24'hFFFFFF, 4'hF, 4'hF, 1'b1, 8'hFF, "all ones");
      // R3 seed does not carry over: repeat zero word after a different one
      req(24'h0, 4'h0, 4'h0, 1'b1, 8'h80, "zero again");
      // R1 field placement: single bit in each field
      req(24'h000001, 4'h0, 4'h0, 1'b0, 8'h7F, "cid lsb");
      req(24'h800000, 4'h0, 4'h0, 1'b0, 8'hA5, "cid msb");
      req(24'h0, 4'h1, 4'h0, 1'b1, 8'h5A, "region lsb");
      req(24'h0, 4'h8, 4'h0, 1'b0, 8'h01, "region msb");
      req(24'h0, 4'h0, 4'h1, 1'b1, 8'hFE, "type lsb");
      req(24'h0, 4'h0, 4'h8, 1'b1, 8'h3C, "type msb");

      // R7 hold while idle with changing inputs
      @(negedge clk);
      held_crc = out_crc; held_tag = out_tag; held_inval = out_inval;
      in_valid = 1'b0; in_cid = 24'h123456; in_region = 4'h9; in_type = 4'h6;
      in_mode = 1'b0; in_stored = 8'hC3;
      @(posedge clk); #1;
      chk("R7 no strobe when idle", {7'd0, out_valid}, 8'd0);
      chk("R7 crc held", out_crc, held_crc);
      chk("R7 tag held", out_tag, held_tag);
      chk("R7 inval held", out_inval, held_inval);
      @(posedge clk); #1;
      chk("R7 crc held 2", out_crc, held_crc);

      // walking single bits over the whole word
      for (int b = 0; b < 32; b++) begin
         logic [31:0] w = 32'd1 << b;
         req(w[31:8], w[7:4], w[3:0], b[0], 8'(b), "walk");
      end

      // back-to-back random requests
      for (int n = 0; n < 400; n++) begin
         req(24'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), 8'($urandom), "random");
      end

      // random with idle gaps
      for (int n = 0; n < 100; n++) begin
         req(24'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), 8'($urandom), "gapped");
         @(negedge clk); in_valid = 1'b0;
         @(posedge clk); #1;
         chk("R7 single-cycle strobe", {7'd0, out_valid}, 8'd0);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule